// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address while the instruction at the current fetch address is still being read. It holds a direct-mapped table of 2^IDX_W entries. Each entry keeps a valid flag, the complete address of a control instruction, and that instruction's last taken target. A lookup that finds a valid entry whose stored address equals the fetch address returns the stored target. Any other lookup returns the sequential address, fetch address plus 4. No decode is needed, and only taken branches and jumps ever occupy an entry.

The table changes only through the resolution port. The execute stage presents each resolved instruction there, together with the next address that fetch actually used and whether that fetch came from a hit. A taken control instruction writes or rewrites its entry. A not-taken control instruction that had hit clears its entry. If the real successor differs from the fetched one, the block raises a one-cycle kill request that carries the correct address.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset clears every valid flag, so each lookup after reset misses until a new entry is written.
- R2: A lookup presented with `fetch_req` high returns its result one cycle later with `pred_valid` high. The table index is fetch address bits [IDX_W+1:2]. When no lookup was presented, `pred_valid` and `pred_hit` are low.
- R3: A lookup hits only when the indexed entry is valid and its stored full address equals the fetch address. On a hit, `pred_next_pc` is the stored target.
- R4: On a miss, `pred_next_pc` equals the fetch address plus 4. This also applies when the indexed entry is valid but holds a different address that maps to the same index.
- R5: A resolved control instruction that was taken writes its entry with valid set, its own address, and its target. This either installs a new entry or replaces whatever occupied that index.
- R6: A resolved control instruction that was not taken, and whose fetch hit (`res_was_hit` high), clears the valid flag of its entry.
- R7: A resolved instruction with `res_ctrl` low never changes any entry.
- R8: The real successor is the target for a taken control instruction and the address plus 4 otherwise. When it differs from `res_fetched_next`, `kill` is high for exactly the next cycle and `kill_pc` holds the real successor. Otherwise `kill` stays low.
- R9: If a lookup and an update hit the same index in the same cycle, the lookup returns the entry as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Lookup request for this cycle |
| fetch_pc | input | PC_W | Address being fetched |
| pred_valid | output | 1 | Lookup result present (one cycle after request) |
| pred_hit | output | 1 | Lookup found a matching valid entry |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A resolved instruction is presented |
| res_pc | input | PC_W | Address of the resolved instruction |
| res_ctrl | input | 1 | Resolved instruction is a branch or jump |
| res_taken | input | 1 | Control instruction was taken |
| res_target | input | PC_W | Resolved target address |
| res_fetched_next | input | PC_W | Next address fetch used after this instruction |
| res_was_hit | input | 1 | Fetch of this instruction hit in the table |
| kill | output | 1 | One-cycle request to discard the wrongly fetched path |
| kill_pc | output | PC_W | Correct address to restart fetch from |

## Verification
The bench builds the block with PC_W = 32 and IDX_W = 4, which gives a 16-entry table. Addresses 64 bytes apart share an index. This makes aliasing between a stored branch and an unrelated instruction easy to produce, along with replacement of one branch by another and same-index collisions between a lookup and an update, all with a few short address patterns. The narrow index changes none of the tag, kill or invalidation logic, which work the same way at any depth.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned PC_STEP = 4;
  localparam int unsigned PC_LSB  = 2;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_CLEAR = 2'd2
  } upd_act_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_idx,
  input  btb_pkg::upd_act_e    wr_act,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [PC_W-1:0]      wr_tag,
  input  logic [PC_W-1:0]      wr_tgt,
  output logic                 rd_valid,
  output logic [PC_W-1:0]      rd_tag,
  output logic [PC_W-1:0]      rd_tgt
);
  import btb_pkg::*;

  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned WORD_W = 2 * PC_W;

  // tag and target live in a plain array so it maps onto block RAM
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word;
  logic [DEPTH-1:0]  vld;
  logic              rd_valid_q;

  // read-first port: a same-cycle write is seen by the next read only
  always_ff @(posedge clk) begin
    if (wr_act == ACT_WRITE) mem[wr_idx] <= {wr_tag, wr_tgt};
    if (rd_en) rd_word <= mem[rd_idx];
  end

  // valid flags sit in flops so reset can clear them in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      case (wr_act)
        ACT_WRITE: vld[wr_idx] <= 1'b1;
        ACT_CLEAR: vld[wr_idx] <= 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_valid_q <= 1'b0;
    else if (rd_en) rd_valid_q <= vld[rd_idx];
  end

  assign rd_valid = rd_valid_q;
  assign rd_tag   = rd_word[WORD_W-1:PC_W];
  assign rd_tgt   = rd_word[PC_W-1:0];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_req,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            rd_valid,
  input  logic [PC_W-1:0] rd_tag,
  input  logic [PC_W-1:0] rd_tgt,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc
);
  import btb_pkg::*;

  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [PC_W-1:0] pc_q;
  logic            req_q;
  logic            match;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      req_q <= fetch_req;
      if (fetch_req) pc_q <= fetch_pc;
    end
  end

  // the full stored address must match, so an aliasing instruction falls through
  assign match        = req_q && rd_valid && (rd_tag == pc_q);
  assign pred_valid   = req_q;
  assign pred_hit     = match;
  assign pred_next_pc = match ? rd_tgt : (pc_q + STEP);

  p_hit_valid_r3: assert property (@(posedge clk) disable iff (rst)
    pred_hit |-> pred_valid);

  p_miss_next_r4: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> (pred_next_pc == $past(fetch_pc) + STEP));
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               res_valid,
  input  logic [PC_W-1:0]    res_pc,
  input  logic               res_ctrl,
  input  logic               res_taken,
  input  logic [PC_W-1:0]    res_target,
  input  logic [PC_W-1:0]    res_fetched_next,
  input  logic               res_was_hit,
  output btb_pkg::upd_act_e  wr_act,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [PC_W-1:0]    wr_tag,
  output logic [PC_W-1:0]    wr_tgt,
  output logic               kill,
  output logic [PC_W-1:0]    kill_pc
);
  import btb_pkg::*;

  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic            redirect;
  logic [PC_W-1:0] true_next;
  logic            kill_q;
  logic [PC_W-1:0] kill_pc_q;

  assign redirect  = res_ctrl && res_taken;
  assign true_next = redirect ? res_target : (res_pc + STEP);

  always_comb begin
    wr_act = ACT_NONE;
    if (res_valid && res_ctrl) begin
      if (res_taken)        wr_act = ACT_WRITE;
      else if (res_was_hit) wr_act = ACT_CLEAR;
    end
  end

  assign wr_idx = res_pc[PC_LSB +: IDX_W];
  assign wr_tag = res_pc;
  assign wr_tgt = res_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_q    <= 1'b0;
      kill_pc_q <= '0;
    end else begin
      kill_q    <= res_valid && (true_next != res_fetched_next);
      kill_pc_q <= true_next;
    end
  end

  assign kill    = kill_q;
  assign kill_pc = kill_pc_q;

  p_kill_after_res_r8: assert property (@(posedge clk) disable iff (rst)
    kill |-> $past(res_valid));

  p_kill_pc_differs_r8: assert property (@(posedge clk) disable iff (rst)
    kill |-> (kill_pc != $past(res_fetched_next)));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_req,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_ctrl,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_fetched_next,
  input  logic            res_was_hit,
  output logic            kill,
  output logic [PC_W-1:0] kill_pc
);
  import btb_pkg::*;

  upd_act_e         wr_act;
  logic [IDX_W-1:0] wr_idx;
  logic [PC_W-1:0]  wr_tag;
  logic [PC_W-1:0]  wr_tgt;
  logic             rd_valid;
  logic [PC_W-1:0]  rd_tag;
  logic [PC_W-1:0]  rd_tgt;

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(fetch_req), .rd_idx(fetch_pc[PC_LSB +: IDX_W]),
    .wr_act(wr_act), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt)
  );

  btb_lookup #(.PC_W(PC_W)) u_lookup (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_next_pc(pred_next_pc)
  );

  btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W)) u_resolve (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_pc(res_pc), .res_ctrl(res_ctrl),
    .res_taken(res_taken), .res_target(res_target),
    .res_fetched_next(res_fetched_next), .res_was_hit(res_was_hit),
    .wr_act(wr_act), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt),
    .kill(kill), .kill_pc(kill_pc)
  );
endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned IDX_W = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_req = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_valid, pred_hit;
  logic [PC_W-1:0] pred_next_pc;
  logic            res_valid = 1'b0, res_ctrl = 1'b0, res_taken = 1'b0, res_was_hit = 1'b0;
  logic [PC_W-1:0] res_pc = '0, res_target = '0, res_fetched_next = '0;
  logic            kill;
  logic [PC_W-1:0] kill_pc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_ctrl(res_ctrl),
    .res_taken(res_taken), .res_target(res_target),
    .res_fetched_next(res_fetched_next), .res_was_hit(res_was_hit),
    .kill(kill), .kill_pc(kill_pc)
  );

  task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc, input string req,
                        input logic exp_hit, input logic [PC_W-1:0] exp_next);
    @(negedge clk);
    fetch_req = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_req = 1'b0;
    chk({req, " valid"}, PC_W'(pred_valid), PC_W'(1));
    chk({req, " hit"}, PC_W'(pred_hit), PC_W'(exp_hit));
    chk({req, " next"}, pred_next_pc, exp_next);
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic ctrl, input logic tkn,
                         input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] fetched,
                         input logic was_hit, input string req,
                         input logic exp_kill, input logic [PC_W-1:0] exp_kpc);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_ctrl = ctrl; res_taken = tkn;
    res_target = tgt; res_fetched_next = fetched; res_was_hit = was_hit;
    @(negedge clk);
    res_valid = 1'b0;
    chk({req, " kill"}, PC_W'(kill), PC_W'(exp_kill));
    if (exp_kill) chk({req, " kill_pc"}, kill_pc, exp_kpc);
  endtask

  task automatic t_reset();
    lookup(32'h100, "R1 after reset", 1'b0, 32'h104);
    @(negedge clk);
    chk("R2 idle pred_valid", PC_W'(pred_valid), '0);
    chk("R2 idle pred_hit", PC_W'(pred_hit), '0);
  endtask

  task automatic t_install();
    resolve(32'h100, 1, 1, 32'h400, 32'h104, 0, "R8 install", 1'b1, 32'h400);
    @(negedge clk);
    chk("R8 kill is one pulse", PC_W'(kill), '0);
    lookup(32'h100, "R5 R3 installed", 1'b1, 32'h400);
  endtask

  task automatic t_alias();
    // 0x140 shares index 0 with 0x100 in a 16-entry table
    lookup(32'h140, "R4 alias miss", 1'b0, 32'h144);
  endtask

  task automatic t_nonctrl();
    resolve(32'h140, 0, 0, 32'h0, 32'h144, 0, "R7 non-control right", 1'b0, '0);
    lookup(32'h100, "R7 entry intact", 1'b1, 32'h400);
    resolve(32'h200, 0, 0, 32'h0, 32'h300, 0, "R8 non-control wrong", 1'b1, 32'h204);
    lookup(32'h200, "R7 no install", 1'b0, 32'h204);
  endtask

  task automatic t_correct();
    resolve(32'h100, 1, 1, 32'h800, 32'h400, 1, "R8 new target", 1'b1, 32'h800);
    lookup(32'h100, "R5 corrected", 1'b1, 32'h800);
    resolve(32'h100, 1, 1, 32'h800, 32'h800, 1, "R8 right guess", 1'b0, '0);
  endtask

  task automatic t_not_taken();
    resolve(32'h100, 1, 0, 32'h800, 32'h800, 1, "R8 not taken", 1'b1, 32'h104);
    lookup(32'h100, "R6 invalidated", 1'b0, 32'h104);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fetch_req = 1'b1; fetch_pc = 32'h180;
    res_valid = 1'b1; res_pc = 32'h180; res_ctrl = 1'b1; res_taken = 1'b1;
    res_target = 32'hA00; res_fetched_next = 32'h184; res_was_hit = 1'b0;
    @(negedge clk);
    fetch_req = 1'b0; res_valid = 1'b0;
    chk("R9 old contents hit", PC_W'(pred_hit), '0);
    chk("R9 old contents next", pred_next_pc, 32'h184);
    lookup(32'h180, "R9 then updated", 1'b1, 32'hA00);
  endtask

  task automatic t_replace();
    resolve(32'h100, 1, 1, 32'h400, 32'h104, 0, "R8 reinstall", 1'b1, 32'h400);
    resolve(32'h140, 1, 1, 32'h900, 32'h144, 0, "R8 alias install", 1'b1, 32'h900);
    lookup(32'h100, "R5 replaced one misses", 1'b0, 32'h104);
    lookup(32'h140, "R5 new owner hits", 1'b1, 32'h900);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    lookup(32'h140, "R1 reset clears", 1'b0, 32'h144);
    lookup(32'h180, "R1 reset clears 2", 1'b0, 32'h184);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_install();
    t_alias();
    t_nonctrl();
    t_correct();
    t_not_taken();
    t_same_cycle();
    t_replace();
    t_reset_again();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule